// File: doc/BRIEF.md
# DDR Write Data Capture with Per-Lane Masking

This block receives write data from a 32-bit double-data-rate memory bus that is split into four byte lanes. Every lane has its own data strobe and its own mask bit. The lane takes one beat on the rising edge of its strobe and a second beat on the falling edge. The data is expected centred between the strobe edges. The mask bit is sampled on the same edge as the data byte it belongs to, so it adds no latency. The two beats of a strobe period form a pair. Each lane writes its pairs into a small asynchronous FIFO. The core-clock side waits until every lane holds a pair. It then presents one 64-bit word together with an 8-bit active-low write enable.

A core-side controller opens a write window with a start pulse and latches the burst-length code at that moment. Each lane counts the pairs it accepts and refuses any beyond the burst length. Strobe edges outside a window are ignored. When the last word of the burst leaves the block, the controller raises a one-cycle done pulse and closes the window.

Top module: `ddrwc_wr_capture`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_vld` and `done` are 0 and `out_we_n` is all ones.
- R2: Lane i (i = 0..3) takes data bits 8i+7..8i from `dq`, uses strobe `dqs[i]` and uses mask `dm[i]`.
- R3: In each output word, bits 31:0 hold the rising-edge beat of all lanes and bits 63:32 hold the falling-edge beat. Lane i sits at bit offset 8i within each half.
- R4: Bit i of `out_we_n` equals the `dm[i]` value sampled with the rising-edge beat. Bit 4+i equals the `dm[i]` value sampled with the falling-edge beat. A 1 means the byte is not written. There is no extra latency between a mask and its beat.
- R5: `bl_sel` is sampled only when a burst starts. Code 0 means 2 beats, code 1 means 4 beats, and codes 2 and 3 mean 8 beats. A burst yields exactly beats/2 output words.
- R6: `done` is high for exactly one cycle, in the same cycle as the last word of the burst.
- R7: Strobe edges that arrive while no burst is open produce no output words and do not disturb the next burst.
- R8: Strobe pairs beyond the burst length, arriving while the burst is still open, are discarded.
- R9: A `wr_start` pulse while a burst is open is ignored. The burst keeps its length and finishes normally.
- R10: The lanes may be skewed against one another. A word is emitted only once all four lanes hold the matching pair, and each lane's bytes stay in their own positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Pulse that opens a write burst |
| bl_sel | input | 2 | Burst length code, latched at start |
| dqs | input | 4 | Per-lane data strobes |
| dq | input | 32 | Write data, four byte lanes |
| dm | input | 4 | Per-lane write mask, high blocks the byte |
| out_vld | output | 1 | Output word valid, one cycle per word |
| out_data | output | 64 | Assembled word: rise beat low, fall beat high |
| out_we_n | output | 8 | Active-low byte enables matching `out_data` |
| done | output | 1 | Pulses with the last word of a burst |

## Verification
The bench runs every burst-length code and drives all 256 byte-enable values through the bursts of eight beats. It skews the lanes against one another by a different amount in every burst. A design that sampled the mask one edge late, or swapped the rise and fall halves, would show shifted enables or shifted bytes. A design that ignored the lane pairing would mix bytes from different pairs under skew. The bench also sends extra strobe pairs past the burst length, repeats the start pulse in the middle of a burst, changes `bl_sel` after the start, and toggles strobes while no burst is open. A design that got any of these wrong would emit extra words, lose words, or pulse `done` at the wrong time.

// File: rtl/ddrwc_pkg.sv
`timescale 1ns/1ps
package ddrwc_pkg;

    localparam int BYTE_W = 8;
    localparam int PAIR_W = 3;

    typedef enum logic [1:0] {
        BLC_TWO   = 2'd0,
        BLC_FOUR  = 2'd1,
        BLC_EIGHT = 2'd2,
        BLC_ALT8  = 2'd3
    } bl_code_e;

    typedef struct packed {
        logic              fall_m;
        logic [BYTE_W-1:0] fall_d;
        logic              rise_m;
        logic [BYTE_W-1:0] rise_d;
    } lane_pair_t;

    // Strobe pairs (rise + fall) per burst for a length code
    function automatic logic [PAIR_W-1:0] bl_pairs(input bl_code_e code);
        case (code)
            BLC_TWO:  return PAIR_W'(1);
            BLC_FOUR: return PAIR_W'(2);
            default:  return PAIR_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/ddrwc_lane_cap.sv
`timescale 1ns/1ps
module ddrwc_lane_cap
    import ddrwc_pkg::*;
#(
    parameter int AW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrst,
    input  logic              dqs,
    input  logic [BYTE_W-1:0] dq,
    input  logic              dm,
    input  logic              arm,
    input  logic              tog,
    input  logic [PAIR_W-1:0] pairs,
    input  logic              pop,
    output logic              ready,
    output lane_pair_t        rd_pair
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    lane_pair_t        mem [DEPTH];
    logic [BYTE_W-1:0] rise_d;
    logic              rise_m;
    logic [PW-1:0]     wbin, wgray, wnext;
    logic [PW-1:0]     rbin, rgray, rnext;
    logic [PW-1:0]     wsync1, wsync2;
    logic              seen;
    logic [PAIR_W-1:0] cnt;
    logic              fresh, wr_ok;
    lane_pair_t        wr_pair;

    // Rising-edge beat and its mask, held until the falling edge
    always_ff @(posedge dqs or posedge wrst) begin
        if (wrst) begin
            rise_d <= '0;
            rise_m <= 1'b1;
        end else begin
            rise_d <= dq;
            rise_m <= dm;
        end
    end

    assign fresh = (tog != seen);
    assign wr_ok = arm && (fresh || (cnt < pairs));
    assign wnext = wbin + PW'(1);

    always_comb begin
        wr_pair.fall_m = dm;
        wr_pair.fall_d = dq;
        wr_pair.rise_m = rise_m;
        wr_pair.rise_d = rise_d;
    end

    // Falling edge completes a pair and pushes it
    always_ff @(negedge dqs or posedge wrst) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
            seen  <= 1'b0;
            cnt   <= '0;
        end else if (wr_ok) begin
            wbin  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
            seen  <= tog;
            cnt   <= fresh ? PAIR_W'(1) : cnt + PAIR_W'(1);
        end
    end

    always_ff @(negedge dqs) begin
        if (wr_ok) begin
            mem[wbin[AW-1:0]] <= wr_pair;
        end
    end

    // Core-clock read side
    assign rnext = rbin + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wsync1 <= '0;
            wsync2 <= '0;
            rbin   <= '0;
            rgray  <= '0;
        end else begin
            wsync1 <= wgray;
            wsync2 <= wsync1;
            if (pop) begin
                rbin  <= rnext;
                rgray <= rnext ^ (rnext >> 1);
            end
        end
    end

    assign ready   = (wsync2 != rgray);
    assign rd_pair = mem[rbin[AW-1:0]];

endmodule

// File: rtl/ddrwc_burst_ctl.sv
`timescale 1ns/1ps
module ddrwc_burst_ctl
    import ddrwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic [1:0]        bl_sel,
    input  logic              pop,
    output logic              arm,
    output logic              tog,
    output logic [PAIR_W-1:0] pairs,
    output logic [PAIR_W-1:0] wcnt,
    output logic              last
);
    assign last = arm && pop && (wcnt == pairs - PAIR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            arm   <= 1'b0;
            tog   <= 1'b0;
            pairs <= PAIR_W'(1);
            wcnt  <= '0;
        end else if (wr_start && !arm) begin
            arm   <= 1'b1;
            tog   <= ~tog;
            pairs <= bl_pairs(bl_code_e'(bl_sel));
            wcnt  <= '0;
        end else if (arm && pop) begin
            if (last) begin
                arm  <= 1'b0;
                wcnt <= '0;
            end else begin
                wcnt <= wcnt + PAIR_W'(1);
            end
        end
    end

endmodule

// File: rtl/ddrwc_wr_capture.sv
`timescale 1ns/1ps
module ddrwc_wr_capture
    import ddrwc_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int FIFO_AW = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_start,
    input  logic [1:0]                bl_sel,
    input  logic [LANES-1:0]          dqs,
    input  logic [LANES*BYTE_W-1:0]   dq,
    input  logic [LANES-1:0]          dm,
    output logic                      out_vld,
    output logic [2*LANES*BYTE_W-1:0] out_data,
    output logic [2*LANES-1:0]        out_we_n,
    output logic                      done
);
    localparam int DQ_W   = LANES * BYTE_W;
    localparam int WORD_W = 2 * DQ_W;

    logic              strobe_rst;
    logic              arm_q, tog_q, last;
    logic [PAIR_W-1:0] pairs_q, wcnt_q;
    logic [LANES-1:0]  lane_ready;
    lane_pair_t        lane_pair [LANES];
    logic              pop;
    logic [WORD_W-1:0] word_d;
    logic [2*LANES-1:0] we_d;

    // Registered copy of reset for the strobe-domain flops
    always_ff @(posedge clk) begin
        strobe_rst <= rst;
    end

    ddrwc_burst_ctl ctl_i (
        .clk      (clk),
        .rst      (rst),
        .wr_start (wr_start),
        .bl_sel   (bl_sel),
        .pop      (pop),
        .arm      (arm_q),
        .tog      (tog_q),
        .pairs    (pairs_q),
        .wcnt     (wcnt_q),
        .last     (last)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ddrwc_lane_cap #(.AW(FIFO_AW)) lane_i (
            .clk     (clk),
            .rst     (rst),
            .wrst    (strobe_rst),
            .dqs     (dqs[g]),
            .dq      (dq[g*BYTE_W +: BYTE_W]),
            .dm      (dm[g]),
            .arm     (arm_q),
            .tog     (tog_q),
            .pairs   (pairs_q),
            .pop     (pop),
            .ready   (lane_ready[g]),
            .rd_pair (lane_pair[g])
        );
    end

    assign pop = &lane_ready;

    always_comb begin
        word_d = '0;
        we_d   = '0;
        for (int i = 0; i < LANES; i++) begin
            word_d[i*BYTE_W +: BYTE_W]        = lane_pair[i].rise_d;
            word_d[DQ_W + i*BYTE_W +: BYTE_W] = lane_pair[i].fall_d;
            we_d[i]                           = lane_pair[i].rise_m;
            we_d[LANES + i]                   = lane_pair[i].fall_m;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_data <= '0;
            out_we_n <= '1;
            done     <= 1'b0;
        end else begin
            out_vld <= pop;
            done    <= last;
            if (pop) begin
                out_data <= word_d;
                out_we_n <= we_d;
            end
        end
    end

endmodule

// File: rtl/ddrwc_wr_capture_chk.sv
`timescale 1ns/1ps
module ddrwc_wr_capture_chk
    import ddrwc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_start,
    input logic              out_vld,
    input logic              done,
    input logic              arm,
    input logic              tog,
    input logic [PAIR_W-1:0] wcnt,
    input logic [PAIR_W-1:0] pairs
);
    AST_DONE_WITH_WORD: assert property (@(posedge clk) disable iff (rst)
        done |-> out_vld); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_WINDOW_CLOSED_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !arm); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        arm |-> (wcnt < pairs)); // R5
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (arm && wr_start) |=> $stable(tog)); // R9
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!arm && !done) |-> !out_vld); // R7
endmodule

bind ddrwc_wr_capture ddrwc_wr_capture_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_start (wr_start),
    .out_vld  (out_vld),
    .done     (done),
    .arm      (arm_q),
    .tog      (tog_q),
    .wcnt     (wcnt_q),
    .pairs    (pairs_q)
);

// File: tb/ddrwc_wr_capture_tb_top.sv
`timescale 1ns/1ps
module ddrwc_wr_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_start = 1'b0;
    logic [1:0]  bl_sel = 2'd0;
    logic [3:0]  dqs = 4'd0;
    logic [3:0]  dm = 4'd0;
    logic [7:0]  dq_l [4];
    logic [31:0] dq;
    logic        out_vld, done;
    logic [63:0] out_data;
    logic [7:0]  out_we_n;

    always #10 clk = ~clk;

    always_comb dq = {dq_l[3], dq_l[2], dq_l[1], dq_l[0]};

    ddrwc_wr_capture dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_start (wr_start),
        .bl_sel   (bl_sel),
        .dqs      (dqs),
        .dq       (dq),
        .dm       (dm),
        .out_vld  (out_vld),
        .out_data (out_data),
        .out_we_n (out_we_n),
        .done     (done)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [63:0] obs_d [0:1023];
    logic [7:0]  obs_w [0:1023];
    int          obs_cnt = 0;
    int          done_cnt = 0;
    int          done_idx = -1;
    bit          finished = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_vld && obs_cnt < 1024) begin
                obs_d[obs_cnt] = out_data;
                obs_w[obs_cnt] = out_we_n;
                obs_cnt = obs_cnt + 1;
            end
            if (done) begin
                done_cnt = done_cnt + 1;
                done_idx = obs_cnt;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rb(int s, int b, int k, int i);
        return 8'(b*37 + k*11 + i*5 + s*19 + 1);
    endfunction

    function automatic logic [7:0] fb(int s, int b, int k, int i);
        return 8'(b*53 + k*7 + i*13 + s*29 + 3);
    endfunction

    function automatic logic [7:0] we_of(int s, int b, int k);
        return 8'(b*4 + k + s*97);
    endfunction

    function automatic logic [63:0] exp_word(int s, int b, int k);
        logic [63:0] w;
        w = '0;
        for (int i = 0; i < 4; i++) begin
            w[8*i +: 8]      = rb(s, b, k, i);
            w[32 + 8*i +: 8] = fb(s, b, k, i);
        end
        return w;
    endfunction

    // One lane: data centred between strobe edges, mask with its beat
    task automatic drive_lane(int i, int s, int b, int np, int skew);
        logic [7:0] we;
        #(skew);
        for (int k = 0; k < np; k++) begin
            we = we_of(s, b, k);
            dq_l[i] = rb(s, b, k, i);
            dm[i]   = we[i];
            #2 dqs[i] = 1'b1;
            #3;
            dq_l[i] = fb(s, b, k, i);
            dm[i]   = we[4+i];
            #2 dqs[i] = 1'b0;
            #3;
        end
        dm[i] = 1'b0;
    endtask

    task automatic drive_all(int s, int b, int np);
        fork
            drive_lane(0, s, b, np, ((0 + b) % 4) * 4);
            drive_lane(1, s, b, np, ((1 + b) % 4) * 4);
            drive_lane(2, s, b, np, ((2 + b) % 4) * 4);
            drive_lane(3, s, b, np, ((3 + b) % 4) * 4);
        join
    endtask

    task automatic run_burst(int s, int b, int extra, bit restart);
        int base;
        int dbase;
        int np;
        int cyc;
        base  = obs_cnt;
        dbase = done_cnt;
        np    = (s == 0) ? 1 : (s == 1) ? 2 : 4;
        @(negedge clk);
        bl_sel   = 2'(s);
        wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
        bl_sel   = 2'(s + 1); // R5: must not affect the open burst
        repeat (2) @(negedge clk);
        fork
            drive_all(s, b, np + extra);
            begin
                if (restart) begin
                    @(negedge clk);
                    wr_start = 1'b1;
                    bl_sel   = 2'd0;
                    @(negedge clk);
                    wr_start = 1'b0;
                end
            end
        join
        cyc = 0;
        while (done_cnt == dbase && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        repeat (8) @(negedge clk);
        check(obs_cnt - base == np, "R5 R8 R9 words per burst", 64'(obs_cnt - base), 64'(np));
        check(done_cnt - dbase == 1, "R6 single done pulse", 64'(done_cnt - dbase), 64'd1);
        check(done_idx == base + np, "R6 done with last word", 64'(done_idx), 64'(base + np));
        for (int k = 0; k < np && (base + k) < obs_cnt; k++) begin
            check(obs_d[base+k] == exp_word(s, b, k), "R2 R3 R10 data word",
                  obs_d[base+k], exp_word(s, b, k));
            check(obs_w[base+k] == we_of(s, b, k), "R4 byte enables",
                  64'(obs_w[base+k]), 64'(we_of(s, b, k)));
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired, all requirements actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int base;
        for (int i = 0; i < 4; i++) dq_l[i] = 8'h00;
        repeat (5) @(negedge clk);
        // R1 during reset
        check(out_vld == 1'b0, "R1 out_vld in reset", 64'(out_vld), 64'd0);
        check(done == 1'b0, "R1 done in reset", 64'(done), 64'd0);
        check(out_we_n == 8'hFF, "R1 we_n in reset", 64'(out_we_n), 64'hFF);
        rst = 1'b0;
        @(negedge clk);
        check(out_vld == 1'b0 && done == 1'b0, "R1 outputs after reset", 64'({out_vld, done}), 64'd0);
        repeat (2) @(negedge clk);

        // R7: strobes with no open burst
        drive_all(0, 7, 2);
        repeat (20) @(negedge clk);
        check(obs_cnt == 0, "R7 idle strobes ignored", 64'(obs_cnt), 64'd0);
        check(done_cnt == 0, "R7 no done when idle", 64'(done_cnt), 64'd0);

        // Sweeps: all length codes, all 256 enable values for 8-beat bursts
        for (int s = 0; s < 3; s++) begin
            for (int b = 0; b < ((s == 2) ? 64 : 8); b++) begin
                run_burst(s, b, (b % 3 == 0) ? 1 : 0, (b % 5 == 1));
            end
        end
        run_burst(3, 5, 0, 1'b0); // R5 code 3

        // R7 after a finished burst, then a clean burst
        base = obs_cnt;
        drive_all(1, 11, 2);
        repeat (20) @(negedge clk);
        check(obs_cnt == base, "R7 strobes after done ignored", 64'(obs_cnt), 64'(base));
        run_burst(2, 9, 0, 1'b0); // R7 next burst undisturbed

        finish_run();
    end

endmodule